// File: doc/BRIEF.md
# Packet Buffer Handshake Controller

This block sits between a processor's control and status registers and a packet router. It runs two independent four-phase handshakes. On the receive side, the router hands a filled buffer to the processor and the processor hands it back. On the transmit side, the processor fills a buffer and hands it to the router, together with a line count. The processor writes one control word and reads one status word. Both words carry a handshake bit for each direction, and the upper half of each word carries a 16-bit line count.

On the router side, the receive direction is a valid/ready transfer that announces a new packet and its length. A single-cycle release pulse tells the router that the processor is done with the receive buffer. The transmit direction issues a single-cycle send pulse with a latched line count, and waits for an acknowledge level from the router. A clear bit in the control word returns both directions to idle: the receive buffer empty and the transmit buffer free.

Top module: `pkt_bufhs_ctrl`

## Requirements
- R1: After reset the status word reads bit 0 = 0 (no receive packet), bit 1 = 1 (transmit buffer free) and bits [31:16] = 0. `rx_ready` is 1, and `rx_free` and `tx_send` are 0.
- R2: A cycle with `rx_valid` and `rx_ready` both high loads the packet. From the next cycle on, status bit 0 is 1, status bits [31:16] equal the `rx_lines` value that was offered, and `rx_ready` is 0.
- R3: A rise of control bit 0 while status bit 0 is 1 clears status bit 0 and status bits [31:16] on the following clock edge. In the same cycle, `rx_free` pulses high for exactly one cycle.
- R4: After a release, `rx_ready` stays 0 for as long as control bit 0 is held high. `rx_ready` returns to 1 on the clock edge that samples control bit 0 low.
- R5: A rise of control bit 1 while status bit 1 is 1 has three effects. It latches control bits [31:16] onto `tx_lines`, pulses `tx_send` for exactly one cycle, and clears status bit 1, all on the following clock edge.
- R6: After a commit, status bit 1 returns to 1 only once `tx_ack` has been seen high and control bit 1 has been sampled low. Either of these may happen first.
- R7: While control bit 8 is high, the block is held idle: status bit 0 = 0, status bit 1 = 1, `rx_ready` = 0, and no pulses. A control bit that is still high when the clear is removed does not count as a rise.
- R8: A line count of zero is carried through unchanged, both on commit (`tx_lines` = 0 with a `tx_send` pulse) and on receive (status bits [31:16] = 0 with status bit 0 = 1).
- R9: Changes to control bits [31:16] without a rise of control bit 1 leave `tx_lines` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_ctrl | input | 32 | Control word: bit 0 release, bit 1 commit, bit 8 clear, [31:16] transmit line count |
| cpu_stat | output | 32 | Status word: bit 0 receive packet held, bit 1 transmit buffer free, [31:16] receive line count |
| rx_valid | input | 1 | Router offers a filled receive buffer |
| rx_lines | input | 16 | Line count of the offered receive packet |
| rx_ready | output | 1 | Receive buffer is empty and may be loaded |
| rx_free | output | 1 | One-cycle pulse: processor released the receive buffer |
| tx_send | output | 1 | One-cycle pulse: processor committed the transmit buffer |
| tx_lines | output | 16 | Line count latched at the last commit |
| tx_ack | input | 1 | Router has taken the committed transmit buffer |

## Verification
The hardest situations to reach from the ports are the two orderings that end a transmit handshake and a clear that arrives while control bits are still held high. In one ordering the router acknowledges while the processor still holds the commit bit. In the other, the processor drops the bit before the acknowledge. Separate tasks drive each order cycle by cycle, and each confirms that the free bit stays low until the second condition is met. For the clear case, the stimulus raises the clear with both handshake bits still high and then removes it. It then offers a new receive packet and checks that the held release bit does not empty the buffer.

// File: rtl/pbh_pkg.sv
package pbh_pkg;
   typedef enum logic [1:0] {
      RX_EMPTY = 2'd0,
      RX_FULL  = 2'd1,
      RX_DRAIN = 2'd2
   } rx_state_e;

   typedef enum logic [1:0] {
      TX_FREE = 2'd0,
      TX_PEND = 2'd1,
      TX_HOLD = 2'd2
   } tx_state_e;
endpackage

// File: rtl/pbh_edge.sv
module pbh_edge #(
   parameter int NBITS = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NBITS-1:0] lvl,
   output logic [NBITS-1:0] rise
);
   logic [NBITS-1:0] prev_q;

   for (genvar gi = 0; gi < NBITS; gi++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) prev_q[gi] <= 1'b0;
         else        prev_q[gi] <= lvl[gi];
      end
      assign rise[gi] = lvl[gi] & ~prev_q[gi];
   end
endmodule

// File: rtl/pbh_rx_side.sv
module pbh_rx_side
   import pbh_pkg::*;
#(
   parameter int LINE_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              rel_lvl,
   input  logic              rel_rise,
   input  logic              in_valid,
   input  logic [LINE_W-1:0] in_lines,
   output logic              in_ready,
   output logic              full,
   output logic [LINE_W-1:0] held_lines,
   output logic              free_pulse
);
   rx_state_e         st_q, st_d;
   logic [LINE_W-1:0] len_q;
   logic              pulse_q;
   logic              take;

   assign in_ready = (st_q == RX_EMPTY) && !clr;
   assign take     = in_ready && in_valid;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         RX_EMPTY: if (take) st_d = RX_FULL;
         RX_FULL:  if (rel_rise) st_d = RX_DRAIN;
         RX_DRAIN: if (!rel_lvl) st_d = RX_EMPTY;
         default:  st_d = RX_EMPTY;
      endcase
      if (clr) st_d = RX_EMPTY;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= RX_EMPTY;
         len_q   <= '0;
         pulse_q <= 1'b0;
      end else begin
         st_q    <= st_d;
         pulse_q <= !clr && (st_q == RX_FULL) && rel_rise;
         if (clr)       len_q <= '0;
         else if (take) len_q <= in_lines;
      end
   end

   assign full       = (st_q == RX_FULL);
   assign held_lines = full ? len_q : '0;
   assign free_pulse = pulse_q;
endmodule

// File: rtl/pbh_tx_side.sv
module pbh_tx_side
   import pbh_pkg::*;
#(
   parameter int LINE_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              com_lvl,
   input  logic              com_rise,
   input  logic [LINE_W-1:0] cnt_in,
   input  logic              ack,
   output logic              avail,
   output logic              send,
   output logic [LINE_W-1:0] lines_o
);
   tx_state_e         st_q, st_d;
   logic [LINE_W-1:0] cnt_q;
   logic              send_q;
   logic              fire;

   assign fire = !clr && (st_q == TX_FREE) && com_rise;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         TX_FREE: if (fire) st_d = TX_PEND;
         TX_PEND: if (ack) st_d = com_lvl ? TX_HOLD : TX_FREE;
         TX_HOLD: if (!com_lvl) st_d = TX_FREE;
         default: st_d = TX_FREE;
      endcase
      if (clr) st_d = TX_FREE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= TX_FREE;
         cnt_q  <= '0;
         send_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         send_q <= fire;
         if (fire) cnt_q <= cnt_in;
      end
   end

   assign avail   = (st_q == TX_FREE);
   assign send    = send_q;
   assign lines_o = cnt_q;
endmodule

// File: rtl/pkt_bufhs_ctrl.sv
module pkt_bufhs_ctrl #(
   parameter int WORD_W  = 32,
   parameter int LINE_W  = 16,
   parameter int REL_BIT = 0,
   parameter int COM_BIT = 1,
   parameter int CLR_BIT = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] cpu_ctrl,
   output logic [WORD_W-1:0] cpu_stat,
   input  logic              rx_valid,
   input  logic [LINE_W-1:0] rx_lines,
   output logic              rx_ready,
   output logic              rx_free,
   output logic              tx_send,
   output logic [LINE_W-1:0] tx_lines,
   input  logic              tx_ack
);
   localparam int CNT_LSB = WORD_W - LINE_W;

   if (LINE_W > WORD_W / 2) begin : g_bad_width
      $error("line count must fit in the upper half of the word");
   end
   if (REL_BIT >= CNT_LSB || COM_BIT >= CNT_LSB || CLR_BIT >= CNT_LSB) begin : g_bad_bits
      $error("control bits overlap the line count field");
   end
   if (REL_BIT == COM_BIT || REL_BIT == CLR_BIT || COM_BIT == CLR_BIT) begin : g_dup_bits
      $error("control bit positions must differ");
   end

   logic [1:0]        hs_lvl, hs_rise;
   logic              clr;
   logic              rx_full, tx_avail;
   logic [LINE_W-1:0] rx_held;

   assign hs_lvl = {cpu_ctrl[COM_BIT], cpu_ctrl[REL_BIT]};
   assign clr    = cpu_ctrl[CLR_BIT];

   pbh_edge #(.NBITS(2)) u_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .lvl  (hs_lvl),
      .rise (hs_rise)
   );

   pbh_rx_side #(.LINE_W(LINE_W)) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .rel_lvl   (hs_lvl[0]),
      .rel_rise  (hs_rise[0]),
      .in_valid  (rx_valid),
      .in_lines  (rx_lines),
      .in_ready  (rx_ready),
      .full      (rx_full),
      .held_lines(rx_held),
      .free_pulse(rx_free)
   );

   pbh_tx_side #(.LINE_W(LINE_W)) u_tx (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr),
      .com_lvl (hs_lvl[1]),
      .com_rise(hs_rise[1]),
      .cnt_in  (cpu_ctrl[WORD_W-1 -: LINE_W]),
      .ack     (tx_ack),
      .avail   (tx_avail),
      .send    (tx_send),
      .lines_o (tx_lines)
   );

   always_comb begin
      cpu_stat                     = '0;
      cpu_stat[REL_BIT]            = rx_full;
      cpu_stat[COM_BIT]            = tx_avail;
      cpu_stat[WORD_W-1 -: LINE_W] = rx_held;
   end
endmodule

// File: rtl/pbh_checker.sv
module pbh_checker #(
   parameter int WORD_W = 32,
   parameter int LINE_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic [WORD_W-1:0] cpu_ctrl,
   input logic [WORD_W-1:0] cpu_stat,
   input logic              rx_valid,
   input logic              rx_ready,
   input logic              rx_free,
   input logic              tx_send,
   input logic              tx_ack
);
   logic clr;
   assign clr = cpu_ctrl[8];

   // R2: an accepted packet is announced on the next cycle
   p_load_r2: assert property (@(posedge clk) disable iff (!rst_n || clr)
      (rx_valid && rx_ready) |=> cpu_stat[0]);

   // R3: release pulse accompanies the status drop
   p_release_r3: assert property (@(posedge clk) disable iff (!rst_n || clr)
      rx_free |-> (!cpu_stat[0] && !$past(rx_free)));

   // R3: length field is zero whenever no packet is held
   p_len_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_stat[0] |-> (cpu_stat[WORD_W-1 -: LINE_W] == '0));

   // R5: send is one cycle wide and the free bit is down with it
   p_send_once_r5: assert property (@(posedge clk) disable iff (!rst_n || clr)
      tx_send |-> (!cpu_stat[1] && !$past(tx_send)));

   // R6: free bit comes back only with commit bit low
   p_reavail_r6: assert property (@(posedge clk) disable iff (!rst_n || clr)
      $rose(cpu_stat[1]) |-> !$past(cpu_ctrl[1]) || $past(clr));

   // R7: clear forces idle
   p_clear_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cpu_stat[1] && !cpu_stat[0] && !tx_send && !rx_free));

   // R4: no receive load accepted while the ready is low
   p_no_ready_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_stat[0] |-> !rx_ready);
endmodule

bind pkt_bufhs_ctrl pbh_checker #(.WORD_W(WORD_W), .LINE_W(LINE_W)) u_pbh_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .cpu_ctrl(cpu_ctrl),
   .cpu_stat(cpu_stat),
   .rx_valid(rx_valid),
   .rx_ready(rx_ready),
   .rx_free (rx_free),
   .tx_send (tx_send),
   .tx_ack  (tx_ack)
);

// File: tb/sim_pkt_bufhs_ctrl.sv
`timescale 1ns/1ps
module sim_pkt_bufhs_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] cpu_ctrl = '0;
   logic [31:0] cpu_stat;
   logic        rx_valid = 1'b0;
   logic [15:0] rx_lines = '0;
   logic        rx_ready, rx_free, tx_send, tx_ack = 1'b0;
   logic [15:0] tx_lines;

   int n_run = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   pkt_bufhs_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .cpu_ctrl(cpu_ctrl), .cpu_stat(cpu_stat),
      .rx_valid(rx_valid), .rx_lines(rx_lines), .rx_ready(rx_ready),
      .rx_free(rx_free), .tx_send(tx_send), .tx_lines(tx_lines), .tx_ack(tx_ack)
   );

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic load_rx(logic [15:0] n);
      rx_valid = 1'b1; rx_lines = n;
      step();
      rx_valid = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 stat", cpu_stat, 32'h0000_0002);
      chk("R1 ready", {31'b0, rx_ready}, 1);
      chk("R1 pulses", {30'b0, rx_free, tx_send}, 0);
   endtask

   task automatic t_rx_basic();
      load_rx(16'h0123);
      chk("R2 stat", cpu_stat, 32'h0123_0003);
      chk("R2 ready low", {31'b0, rx_ready}, 0);
      cpu_ctrl[0] = 1'b1;
      step();
      chk("R3 stat drop", cpu_stat, 32'h0000_0002);
      chk("R3 free pulse", {31'b0, rx_free}, 1);
      step();
      chk("R3 pulse one cycle", {31'b0, rx_free}, 0);
      chk("R4 ready held low", {31'b0, rx_ready}, 0);
      step();
      chk("R4 still low", {31'b0, rx_ready}, 0);
      cpu_ctrl[0] = 1'b0;
      step();
      chk("R4 ready back", {31'b0, rx_ready}, 1);
   endtask

   task automatic t_tx_ack_first();
      cpu_ctrl[31:16] = 16'h0042;
      cpu_ctrl[1] = 1'b1;
      step();
      chk("R5 send", {31'b0, tx_send}, 1);
      chk("R5 lines", {16'b0, tx_lines}, 32'h42);
      chk("R5 free low", {31'b0, cpu_stat[1]}, 0);
      step();
      chk("R5 send one cycle", {31'b0, tx_send}, 0);
      tx_ack = 1'b1;
      step();
      tx_ack = 1'b0;
      chk("R6 wait ctrl low", {31'b0, cpu_stat[1]}, 0);
      step();
      chk("R6 still waiting", {31'b0, cpu_stat[1]}, 0);
      cpu_ctrl[1] = 1'b0;
      step();
      chk("R6 free after both", {31'b0, cpu_stat[1]}, 1);
   endtask

   task automatic t_tx_ctrl_first();
      cpu_ctrl[31:16] = 16'h0000;
      cpu_ctrl[1] = 1'b1;
      step();
      chk("R8 zero send", {31'b0, tx_send}, 1);
      chk("R8 zero lines", {16'b0, tx_lines}, 0);
      cpu_ctrl[1] = 1'b0;
      step();
      step();
      chk("R6 waits for ack", {31'b0, cpu_stat[1]}, 0);
      tx_ack = 1'b1;
      step();
      tx_ack = 1'b0;
      chk("R6 free after ack", {31'b0, cpu_stat[1]}, 1);
   endtask

   task automatic t_zero_rx();
      load_rx(16'h0000);
      chk("R8 zero rx", cpu_stat, 32'h0000_0003);
      cpu_ctrl[0] = 1'b1; step();
      cpu_ctrl[0] = 1'b0; step();
   endtask

   task automatic t_ignore();
      cpu_ctrl[31:16] = 16'hBEEF;
      step();
      cpu_ctrl[31:16] = 16'h1234;
      step();
      chk("R9 lines unchanged", {16'b0, tx_lines}, 0);
   endtask

   task automatic t_clear();
      load_rx(16'h0077);
      cpu_ctrl[0] = 1'b1;
      cpu_ctrl[31:16] = 16'h0005;
      cpu_ctrl[1] = 1'b1;
      step();
      step();
      cpu_ctrl[8] = 1'b1;
      rx_valid = 1'b1; rx_lines = 16'h0009;
      step();
      chk("R7 idle stat", cpu_stat, 32'h0000_0002);
      chk("R7 ready low", {31'b0, rx_ready}, 0);
      chk("R7 no pulses", {30'b0, rx_free, tx_send}, 0);
      step();
      chk("R7 still idle", cpu_stat, 32'h0000_0002);
      cpu_ctrl[8] = 1'b0;
      step();
      rx_valid = 1'b0;
      chk("R7 load after clear", cpu_stat, 32'h0009_0003);
      step();
      chk("R7 held bits no rise", cpu_stat, 32'h0009_0003);
      chk("R7 no send", {31'b0, tx_send}, 0);
   endtask

   initial begin : wd
      repeat (5000) @(posedge clk);
      n_run++; n_bad++;
      $display("FAIL watchdog: got timeout expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
   end

   initial begin
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_rx_basic();
      t_tx_ack_first();
      t_tx_ctrl_first();
      t_zero_rx();
      t_ignore();
      t_clear();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
   end
endmodule